// File: doc/BRIEF.md
# Display Memory Bus-Request Arbiter

This block settles contention between the processor and the video refresh engine over display memory. The address decoder upstream tells it, access by access, whether the current cycle touches a display-class page. Such pages include graphics frame memory, text memory and the window into the display controller. The video timing generator supplies separate horizontal and vertical blanking levels.

When the processor reaches display memory while the picture is being drawn, the block raises a bus request that stalls the processor. The stall does not last a fixed number of cycles. It stays up until the next blanking interval begins, which is when the refresh engine stops needing the memory. The request drops on that edge. Accesses made during blanking, or to ordinary memory, pass without a stall. The blanking inputs may come from another clock domain, so they are brought in through a two-flop synchroniser before any edge is detected.

Top module: `dm_busreq_arbiter`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the cycle after it, `busreq_o` and `blank_o` are 0. This holds even if a request was pending when reset arrived.
- R2: A cycle with `acc_valid`=1 and `acc_display`=1 while `blank_o`=0 sets `busreq_o` to 1 from the next clock edge.
- R3: A display access made while `blank_o`=1 leaves `busreq_o` at 0.
- R4: A cycle with `acc_display`=0, or with `acc_valid`=0, never raises `busreq_o`.
- R5: Once raised, `busreq_o` stays at 1 for as long as blanking stays low, however long that lasts.
- R6: `busreq_o` falls on the clock edge after `blank_o` rises. That is the third rising clock edge after a blanking input changes from 0 to 1.
- R7: Either blanking input, on its own, starts a blanking interval and releases the request.
- R8: Further display accesses while the request is already up have no extra effect. A single blanking rise releases the request.
- R9: If a display access and a blanking rise are seen in the same cycle, the release wins and `busreq_o` is 0 afterwards.
- R10: When blanking falls, the request is not raised by that alone. A display access made after `blank_o` returns to 0 raises the request again.
- R11: `blank_o` is the OR of `hblank_in` and `vblank_in`, delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Processor memory access in this cycle |
| acc_display | input | 1 | The access targets a display-class page |
| hblank_in | input | 1 | Horizontal blanking level from the video timing, may be asynchronous |
| vblank_in | input | 1 | Vertical blanking level from the video timing, may be asynchronous |
| busreq_o | output | 1 | Bus request that stalls the processor |
| blank_o | output | 1 | Synchronised combined blanking level |

## Verification
The block has two functions that can act in the same cycle: setting the stall on a display access, and releasing it on the blanking rise. The bench provokes this by presenting a display access on exactly the edge where the synchronised blanking goes high. It does so once with a request already pending and once without one. In both cases `busreq_o` must read 0 on the following cycle, because an access made during blanking does not count and the rise clears any pending stall.

// File: rtl/dmba_pkg.sv
// Package: shared types and defaults for the display memory bus-request arbiter.
// Assumes: nothing; it holds declarations only.
package dmba_pkg;

    // Number of flops in the blanking synchroniser chain
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Number of independent blanking sources merged into one blank level
    localparam int unsigned BLANK_SRC_DEF = 2;

    // Request tracker state
    typedef enum logic {
        REQ_IDLE  = 1'b0,
        REQ_STALL = 1'b1
    } req_state_t;

endpackage

// File: rtl/dmba_sync.sv
// Module: multi-bit, multi-stage flop synchroniser for level signals.
// Assumes: each bit is an independent slow-changing level; no bus coherence
// is needed across bits. Reset drives every stage to 0.
module dmba_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // First stage: capture the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= d_in;
    end

    // Remaining stages: shift the captured value down the chain
    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= '0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/dmba_blank_edge.sv
// Module: merges synchronised blanking sources into one level and flags the
// cycle in which that level goes from low to high.
// Assumes: inputs are already synchronous to clk.
module dmba_blank_edge #(
    parameter int unsigned SRC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] blank_src,
    output logic           blank_lvl,
    output logic           blank_rise
);

    logic blank_prev_q;

    // Combined blank: any source active means blanking
    assign blank_lvl = |blank_src;

    // Remember last cycle's combined blank for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) blank_prev_q <= 1'b0;
        else        blank_prev_q <= blank_lvl;
    end

    assign blank_rise = blank_lvl & ~blank_prev_q;

endmodule

// File: rtl/dmba_req_track.sv
// Module: tracks a pending bus request. A display access outside blanking
// starts a stall; the start of blanking ends it. Release takes priority.
// Assumes: acc_hit is already qualified by a valid access strobe.
module dmba_req_track
    import dmba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_hit,
    input  logic blank_lvl,
    input  logic blank_rise,
    output logic busreq
);

    req_state_t state_q, state_d;

    // Next-state decision: release on blank rise, stall on visible-time hit
    always_comb begin
        state_d = state_q;
        if (blank_rise) begin
            state_d = REQ_IDLE;
        end else if (state_q == REQ_IDLE && acc_hit && !blank_lvl) begin
            state_d = REQ_STALL;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    assign busreq = (state_q == REQ_STALL);

endmodule

// File: rtl/dm_busreq_arbiter.sv
// Module: top of the display memory bus-request arbiter. Synchronises the
// two blanking inputs, forms the combined blank and its rising edge, and
// holds a processor stall from a visible-time display access until blanking.
// Assumes: acc_valid/acc_display are synchronous to clk; blanking inputs may
// be asynchronous.
module dm_busreq_arbiter #(
    parameter int unsigned SYNC_STAGES = dmba_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_valid,
    input  logic acc_display,
    input  logic hblank_in,
    input  logic vblank_in,
    output logic busreq_o,
    output logic blank_o
);

    localparam int unsigned NSRC = dmba_pkg::BLANK_SRC_DEF;

    logic [NSRC-1:0] blank_raw;
    logic [NSRC-1:0] blank_sync;
    logic            blank_lvl;
    logic            blank_rise;
    logic            acc_hit;

    // Gather blanking sources in a fixed order: bit 0 horizontal, bit 1 vertical
    assign blank_raw = {vblank_in, hblank_in};

    // Qualified display access
    assign acc_hit = acc_valid & acc_display;

    dmba_sync #(
        .WIDTH  (NSRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (blank_raw),
        .q_out (blank_sync)
    );

    dmba_blank_edge #(
        .SRC (NSRC)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank_src  (blank_sync),
        .blank_lvl  (blank_lvl),
        .blank_rise (blank_rise)
    );

    dmba_req_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_hit    (acc_hit),
        .blank_lvl  (blank_lvl),
        .blank_rise (blank_rise),
        .busreq     (busreq_o)
    );

    assign blank_o = blank_lvl;

endmodule

// File: rtl/dm_busreq_arbiter_chk.sv
// Checker: temporal properties of the arbiter, observed at its ports.
// Assumes: bound to every dm_busreq_arbiter instance.
module dm_busreq_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_valid,
    input logic acc_display,
    input logic hblank_in,
    input logic vblank_in,
    input logic busreq_o,
    input logic blank_o
);

    // R1: reset clears request and blank
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!busreq_o && !blank_o));

    // R2: visible-time display access raises the request
    a_r2_visible_hit_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_display && !blank_o) |=> busreq_o);

    // R3: no new request while blanking is high
    a_r3_blank_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o && !busreq_o) |=> !busreq_o);

    // R4: non-display or idle cycles never raise the request
    a_r4_other_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_valid && acc_display) && !busreq_o) |=> !busreq_o);

    // R5: request held until blanking rises
    a_r5_hold_until_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (busreq_o && !$rose(blank_o)) |=> busreq_o);

    // R6: blanking rise releases the request
    a_r6_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_o) |=> !busreq_o);

endmodule

bind dm_busreq_arbiter dm_busreq_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_display (acc_display),
    .hblank_in   (hblank_in),
    .vblank_in   (vblank_in),
    .busreq_o    (busreq_o),
    .blank_o     (blank_o)
);

// File: tb/dm_busreq_arbiter_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each; inputs change and outputs are
// sampled just after the falling clock edge.
module dm_busreq_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic acc_display = 1'b0;
    logic hblank_in = 1'b0;
    logic vblank_in = 1'b0;
    logic busreq_o;
    logic blank_o;

    int n_checks = 0;
    int n_errors = 0;

    // 50 MHz clock
    always #10 clk = ~clk;

    dm_busreq_arbiter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_display (acc_display),
        .hblank_in   (hblank_in),
        .vblank_in   (vblank_in),
        .busreq_o    (busreq_o),
        .blank_o     (blank_o)
    );

    // Advance n falling edges
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare one bit and record the result
    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // One-cycle display access
    task automatic hit_once();
        acc_valid = 1'b1; acc_display = 1'b1;
        step(1);
        acc_valid = 1'b0; acc_display = 1'b0;
    endtask

    // Return both blanking inputs low and let them settle
    task automatic blank_off();
        hblank_in = 1'b0; vblank_in = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        check(busreq_o, 1'b0, "R1 busreq in reset");
        check(blank_o, 1'b0, "R1 blank in reset");
        rst_n = 1'b1;
        step(1);
        check(busreq_o, 1'b0, "R1 busreq after reset");
    endtask

    task automatic t_basic_hblank();
        hit_once();
        check(busreq_o, 1'b1, "R2 stall after visible hit");
        for (int i = 0; i < 20; i++) begin
            step(1);
            check(busreq_o, 1'b1, "R5 hold while visible");
        end
        hblank_in = 1'b1;
        step(1);
        check(blank_o, 1'b0, "R11 blank after one edge");
        check(busreq_o, 1'b1, "R6 still held after one edge");
        step(1);
        check(blank_o, 1'b1, "R11 blank after two edges");
        check(busreq_o, 1'b1, "R6 still held after two edges");
        step(1);
        check(busreq_o, 1'b0, "R6 released on third edge");
        blank_off();
        check(blank_o, 1'b0, "R11 blank low again");
        check(busreq_o, 1'b0, "R10 blank fall does not stall");
    endtask

    task automatic t_access_in_blank();
        vblank_in = 1'b1;
        step(3);
        check(blank_o, 1'b1, "R11 vertical blank alone");
        hit_once();
        step(1);
        check(busreq_o, 1'b0, "R3 no stall during blank");
        blank_off();
    endtask

    task automatic t_nondisplay();
        acc_valid = 1'b1; acc_display = 1'b0;
        step(5);
        check(busreq_o, 1'b0, "R4 non-display access");
        acc_valid = 1'b0; acc_display = 1'b1;
        step(5);
        check(busreq_o, 1'b0, "R4 display flag without valid");
        acc_display = 1'b0;
    endtask

    task automatic t_vblank_release();
        hit_once();
        check(busreq_o, 1'b1, "R2 stall before vertical release");
        vblank_in = 1'b1;
        step(2);
        check(busreq_o, 1'b1, "R5 held until synced blank");
        step(1);
        check(busreq_o, 1'b0, "R7 vertical blank releases");
        blank_off();
    endtask

    task automatic t_repeat();
        hit_once();
        acc_valid = 1'b1; acc_display = 1'b1;
        step(5);
        check(busreq_o, 1'b1, "R8 repeated hits keep stall");
        acc_valid = 1'b0; acc_display = 1'b0;
        hblank_in = 1'b1;
        step(3);
        check(busreq_o, 1'b0, "R8 one rise releases");
        step(4);
        check(busreq_o, 1'b0, "R8 stays released in blank");
        blank_off();
    endtask

    task automatic t_collide(input logic pend);
        if (pend) hit_once();
        check(busreq_o, pend, "R9 setup");
        hblank_in = 1'b1;
        step(2);
        acc_valid = 1'b1; acc_display = 1'b1;
        step(1);
        acc_valid = 1'b0; acc_display = 1'b0;
        check(busreq_o, 1'b0, "R9 release wins over hit");
        blank_off();
    endtask

    task automatic t_refire();
        hblank_in = 1'b1;
        step(3);
        hblank_in = 1'b0;
        step(2);
        check(blank_o, 1'b0, "R10 blank fell");
        check(busreq_o, 1'b0, "R10 no stall from fall");
        hit_once();
        check(busreq_o, 1'b1, "R10 new hit after blank stalls");
        vblank_in = 1'b1;
        step(3);
        check(busreq_o, 1'b0, "R7 release by vertical");
        blank_off();
    endtask

    task automatic t_mid_reset();
        hit_once();
        check(busreq_o, 1'b1, "R1 setup pending");
        rst_n = 1'b0;
        step(1);
        check(busreq_o, 1'b0, "R1 reset drops pending");
        rst_n = 1'b1;
        step(1);
        check(busreq_o, 1'b0, "R1 after mid reset");
    endtask

    // Summary line and end of run
    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        step(1);
        t_reset();
        t_basic_hblank();
        t_access_in_blank();
        t_nondisplay();
        t_vblank_release();
        t_repeat();
        t_collide(1'b1);
        t_collide(1'b0);
        t_refire();
        t_mid_reset();
        finish_run();
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule